// File: doc/BRIEF.md
# Externally Clocked Serial Output Port

This block holds one converter result in an output shift register and hands it to a host one bit at a time. The host supplies the shift clock and an active-low chip select. The port keeps a free-running frame of `FRAME_LEN` master-clock cycles. At every frame boundary the output register takes the latest word from a staging register, and the ready flag goes low to show that fresh data is waiting. When the frame has `GAP_LEN` cycles left, the ready flag goes high so the host knows a reload is coming.

A read that the host starts but does not finish holds the register: frames keep counting, but the ready gap and the reload are skipped while the select stays asserted. Once the select is released, the unread bits stay in place until the next gap, and the word is then replaced. The serial clock and the select come from outside and pass through synchronizers in the master-clock domain. A data-valid strobe from the converter side writes new words into the staging register.

Top module: `ser_out_port`

## Requirements
- R1: While reset is asserted, `drdy` is 1 and `sdata_oe` is 0.
- R2: On the first clock edge after reset, and every `FRAME_LEN` cycles after that, the output register reloads and `drdy` goes to 0. `drdy` falls at no other time.
- R3: With no read in progress, `drdy` goes to 1 exactly `FRAME_LEN-GAP_LEN` cycles after a reload and stays at 1 for `GAP_LEN` cycles. With the defaults these numbers are 1020 and 4.
- R4: While `drdy` is 0, a low `cs_n` is recognized 3 clock cycles after it changes. `sdata_oe` then goes to 1, and `sdata` shows bit `WORD_W-1` (the MSB) of the loaded word.
- R5: Each falling edge of `sclk_in` seen while a read is active moves `sdata` to the next lower bit. The change appears 3 clock cycles after the edge.
- R6: On the `WORD_W`-th falling edge, `drdy` goes to 1 and `sdata_oe` goes to 0. They stay that way until the next reload, even if `cs_n` is held low.
- R7: If the select is still recognized at the gap point, there is no gap and no reload. `drdy` stays 0 and the partly read word stays at its current bit across the frame boundary.
- R8: When `cs_n` goes high, `sdata_oe` drops 3 cycles later. The unread bits are kept: if `cs_n` goes low again before the gap, the output resumes at the same bit. If it does not, the next gap and reload take place.
- R9: A low `cs_n` during the ready gap is ignored (`sdata_oe` stays 0). It is recognized once `drdy` falls, and the port then shows the MSB of the new word.
- R10: A pulse on `word_stb` writes `word_in` into the staging register. A reload takes the most recently strobed word. A strobe in the same cycle as a reload is loaded directly.
- R11: Falling edges of `sclk_in` while the select is not recognized do not move the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; all logic runs on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk_in | input | 1 | Serial shift clock from the host, asynchronous |
| cs_n | input | 1 | Active-low select from the host, asynchronous |
| word_in | input | WORD_W | Converter result |
| word_stb | input | 1 | One-cycle strobe that writes `word_in` into staging |
| sdata | output | 1 | Serial data bit, 0 while not enabled |
| sdata_oe | output | 1 | Output enable for the external three-state driver of `sdata` |
| drdy | output | 1 | Ready flag: low while fresh data is waiting |

## Verification
Timing is counted from the stimulus. A reload and its `drdy` fall show up one cycle after the frame counter wraps. A change on `cs_n` or a falling `sclk_in` reaches `sdata_oe` or `sdata` three cycles later: two synchronizer stages plus one state register. The bench drives inputs on the falling clock edge and samples exactly three falling edges later. It keeps its own count of frame position, so reload, gap start and gap end are checked in the exact cycle: 1019 low, 1020 high, 1023 high, then low again on the next frame. The hold and resume cases are checked on both sides of frame boundaries.

// File: rtl/ser_out_pkg.sv
package ser_out_pkg;

    // Control state kept by the top-level sequencer.
    typedef struct packed {
        logic drdy;    // ready flag, high = no fresh data / gap
        logic cs_rec;  // select recognized for the current word
    } ctl_t;

    localparam logic DRDY_IDLE = 1'b1;

endpackage

// File: rtl/sp_sync_edge.sv
module sp_sync_edge #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout,
    output logic fall
);

    logic [STAGES-1:0] chain_d, chain_q;
    logic              last_d, last_q;

    assign chain_d[0] = din;
    for (genvar i = 1; i < STAGES; i++) begin : g_chain
        assign chain_d[i] = chain_q[i-1];
    end

    always_comb begin
        last_d = chain_q[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
            last_q  <= RST_VAL;
        end else begin
            chain_q <= chain_d;
            last_q  <= last_d;
        end
    end

    assign dout = chain_q[STAGES-1];
    assign fall = last_q & ~dout;

    AST_FALL_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);  // R5

endmodule

// File: rtl/sp_frame_timer.sv
module sp_frame_timer #(
    parameter int FRAME_LEN = 1024,
    parameter int GAP_LEN   = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic wrap,
    output logic gap_pt
);

    localparam int CNT_W = $clog2(FRAME_LEN);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(FRAME_LEN - 1);
    localparam logic [CNT_W-1:0] GAP_CNT  = CNT_W'(FRAME_LEN - GAP_LEN - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (cnt_q == LAST_CNT) cnt_d = '0;
        else                   cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= LAST_CNT;  // first edge after reset reloads
        else        cnt_q <= cnt_d;
    end

    assign wrap   = (cnt_q == LAST_CNT);
    assign gap_pt = (cnt_q == GAP_CNT);

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_CNT);  // R2

endmodule

// File: rtl/sp_shift_reg.sv
module sp_shift_reg #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic              shift,
    output logic              msb,
    output logic              last_bit
);

    localparam int LEFT_W = $clog2(WORD_W + 1);

    typedef struct packed {
        logic [WORD_W-1:0] sr;
        logic [LEFT_W-1:0] left;
    } sr_t;

    sr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.sr   = load_word;
            st_d.left = LEFT_W'(WORD_W);
        end else if (shift && st_q.left != '0) begin
            st_d.sr   = {st_q.sr[WORD_W-2:0], 1'b0};
            st_d.left = st_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign msb      = st_q.sr[WORD_W-1];
    assign last_bit = (st_q.left == LEFT_W'(1));

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !shift) |=> $stable(st_q.sr));  // R7
    AST_BIT_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !load && st_q.left != '0) |=> (st_q.left == $past(st_q.left) - 1'b1));  // R5

endmodule

// File: rtl/ser_out_port.sv
module ser_out_port
    import ser_out_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int FRAME_LEN   = 1024,
    parameter int GAP_LEN     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_in,
    input  logic              cs_n,
    input  logic [WORD_W-1:0] word_in,
    input  logic              word_stb,
    output logic              sdata,
    output logic              sdata_oe,
    output logic              drdy
);

    logic cs_sync, cs_fall_unused;
    logic sclk_sync, sclk_fall;
    logic wrap, gap_pt;
    logic msb, last_bit;
    logic load, shift, cs_act;
    logic [WORD_W-1:0] stage_d, stage_q, load_word;
    ctl_t ctl_d, ctl_q;

    sp_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
        .clk(clk), .rst_n(rst_n), .din(cs_n), .dout(cs_sync), .fall(cs_fall_unused)
    );

    sp_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sclk_sync (
        .clk(clk), .rst_n(rst_n), .din(sclk_in), .dout(sclk_sync), .fall(sclk_fall)
    );

    sp_frame_timer #(.FRAME_LEN(FRAME_LEN), .GAP_LEN(GAP_LEN)) u_timer (
        .clk(clk), .rst_n(rst_n), .wrap(wrap), .gap_pt(gap_pt)
    );

    sp_shift_reg #(.WORD_W(WORD_W)) u_sr (
        .clk(clk), .rst_n(rst_n), .load(load), .load_word(load_word),
        .shift(shift), .msb(msb), .last_bit(last_bit)
    );

    assign cs_act = ~cs_sync;

    always_comb begin
        // staging register with same-cycle bypass
        stage_d   = word_stb ? word_in : stage_q;
        load_word = stage_d;

        // reload only once the ready flag is up (gap taken or word drained)
        load  = wrap & ctl_q.drdy;
        shift = sclk_fall & ctl_q.cs_rec & ~ctl_q.drdy;

        ctl_d = ctl_q;
        if (load) begin
            ctl_d.drdy = 1'b0;
        end else if (shift && last_bit) begin
            ctl_d.drdy = 1'b1;
        end else if (gap_pt && !ctl_q.cs_rec) begin
            ctl_d.drdy = 1'b1;
        end
        ctl_d.cs_rec = cs_act & ~ctl_q.drdy & ~(shift & last_bit);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.drdy   <= DRDY_IDLE;
            ctl_q.cs_rec <= 1'b0;
            stage_q      <= '0;
        end else begin
            ctl_q   <= ctl_d;
            stage_q <= stage_d;
        end
    end

    assign drdy     = ctl_q.drdy;
    assign sdata_oe = ctl_q.cs_rec & ~ctl_q.drdy;
    assign sdata    = sdata_oe & msb;

    AST_OE_ONLY_DRDY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        sdata_oe |-> !drdy);  // R6
    AST_DRDY_FALL_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drdy) |-> $past(wrap));  // R2
    AST_CS_RELEASE_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !sdata_oe);  // R8
    AST_NO_SHIFT_UNSELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_fall && !ctl_q.cs_rec && !wrap) |=> $stable(sdata));  // R11

endmodule

// File: tb/ser_out_port_tb.sv
module ser_out_port_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WORD_W     = 16;
    localparam int FRAME_LEN  = 1024;
    localparam int GAP_LEN    = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk_in = 1'b0;
    logic cs_n = 1'b1;
    logic [WORD_W-1:0] word_in = '0;
    logic word_stb = 1'b0;
    logic sdata, sdata_oe, drdy;

    int n_chk = 0;
    int n_bad = 0;
    int ph = FRAME_LEN - 1;
    int fr = -1;
    bit finished = 0;

    localparam logic [WORD_W-1:0] W_A = 16'hB234;
    localparam logic [WORD_W-1:0] W_B = 16'hA5C3;
    localparam logic [WORD_W-1:0] W_C = 16'h5A3C;
    localparam logic [WORD_W-1:0] W_D = 16'hF00F;
    localparam logic [WORD_W-1:0] W_E = 16'h0FF0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ser_out_port #(.WORD_W(WORD_W), .FRAME_LEN(FRAME_LEN), .GAP_LEN(GAP_LEN)) u_dut (
        .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .cs_n(cs_n),
        .word_in(word_in), .word_stb(word_stb),
        .sdata(sdata), .sdata_oe(sdata_oe), .drdy(drdy)
    );

    // bench frame position: phase 0 is the cycle right after a reload
    always @(posedge clk) begin
        if (!rst_n) begin
            ph <= FRAME_LEN - 1;
            fr <= -1;
        end else if (ph == FRAME_LEN - 1) begin
            ph <= 0;
            fr <= fr + 1;
        end else begin
            ph <= ph + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (frame %0d phase %0d)", req, act, exp, fr, ph);
        end
    endtask

    task automatic goto(input int f, input int p);
        while (!(fr == f && ph == p)) @(negedge clk);
    endtask

    task automatic strobe(input logic [WORD_W-1:0] w);
        word_in  = w;
        word_stb = 1'b1;
        @(negedge clk);
        word_stb = 1'b0;
    endtask

    // one host clock pulse; check the bit that appears after its falling edge
    task automatic pulse_chk(input string req, input int exp_bit);
        sclk_in = 1'b1;
        repeat (4) @(negedge clk);
        sclk_in = 1'b0;
        repeat (3) @(negedge clk);
        chk(req, int'(sdata), exp_bit);
        @(negedge clk);
    endtask

    task automatic pulse_only();
        sclk_in = 1'b1;
        repeat (4) @(negedge clk);
        sclk_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1 reset state
        word_in  = W_A;
        word_stb = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 drdy in reset", int'(drdy), 1);
        chk("R1 oe in reset", int'(sdata_oe), 0);
        rst_n = 1'b1;          // strobe still high: bypass load of A (R10)
        @(negedge clk);
        word_stb = 1'b0;
        chk("R2 drdy after first load", int'(drdy), 0);
        chk("R2 oe after first load", int'(sdata_oe), 0);

        // frame 0: word A
        goto(0, 100);
        strobe(W_B);
        goto(0, 300);
        cs_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R4 oe on select", int'(sdata_oe), 1);
        chk("R10 bypass loaded A msb", int'(sdata), int'(W_A[15]));
        pulse_chk("R5 A bit14", int'(W_A[14]));
        cs_n = 1'b1;
        goto(0, 1019);
        chk("R3 drdy before gap", int'(drdy), 0);
        @(negedge clk);
        chk("R3 drdy gap start", int'(drdy), 1);
        goto(0, 1023);
        chk("R3 drdy gap end", int'(drdy), 1);
        @(negedge clk);
        chk("R2 drdy falls at reload", int'(drdy), 0);

        // frame 1: word B, host clock while unselected, then full read
        goto(1, 50);
        pulse_only();
        pulse_only();
        chk("R11 oe unselected", int'(sdata_oe), 0);
        goto(1, 100);
        cs_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R11 msb unmoved by stray clocks", int'(sdata), int'(W_B[15]));
        for (int i = WORD_W - 2; i >= 0; i--) pulse_chk("R5 B bit", int'(W_B[i]));
        sclk_in = 1'b1;
        repeat (4) @(negedge clk);
        sclk_in = 1'b0;
        repeat (3) @(negedge clk);
        chk("R6 drdy after last bit", int'(drdy), 1);
        chk("R6 oe after last bit", int'(sdata_oe), 0);
        goto(1, 600);
        chk("R6 drdy held with cs low", int'(drdy), 1);
        chk("R6 oe held with cs low", int'(sdata_oe), 0);
        goto(1, 700);
        strobe(W_C);

        // frame 2: word C, select still low
        goto(2, 0);
        chk("R6 reload after drained word", int'(drdy), 0);
        chk("R9 oe at reload edge", int'(sdata_oe), 0);
        goto(2, 2);
        chk("R9 oe after drdy falls", int'(sdata_oe), 1);
        chk("R10 staged C msb", int'(sdata), int'(W_C[15]));
        goto(2, 10);
        pulse_chk("R5 C bit14", int'(W_C[14]));
        pulse_chk("R5 C bit13", int'(W_C[13]));
        pulse_chk("R5 C bit12", int'(W_C[12]));
        goto(2, 800);
        strobe(W_D);
        goto(2, 1020);
        chk("R7 no gap while held", int'(drdy), 0);
        goto(3, 5);
        chk("R7 drdy low across boundary", int'(drdy), 0);
        chk("R7 oe across boundary", int'(sdata_oe), 1);
        chk("R7 word frozen", int'(sdata), int'(W_C[12]));
        goto(3, 100);
        cs_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R8 oe drops on release", int'(sdata_oe), 0);
        goto(3, 200);
        cs_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8 oe resumes", int'(sdata_oe), 1);
        chk("R8 resumes same bit", int'(sdata), int'(W_C[12]));
        goto(3, 300);
        cs_n = 1'b1;
        goto(3, 1020);
        chk("R8 gap after release", int'(drdy), 1);

        // frame 4: word D
        goto(4, 50);
        cs_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8 reloaded D msb", int'(sdata), int'(W_D[15]));
        goto(4, 60);
        cs_n = 1'b1;
        goto(4, 500);
        strobe(W_E);
        goto(4, 1021);
        cs_n = 1'b0;
        goto(4, 1023);
        chk("R9 select ignored in gap", int'(sdata_oe), 0);
        chk("R9 drdy in gap", int'(drdy), 1);

        // frame 5: word E
        goto(5, 0);
        chk("R9 oe at reload", int'(sdata_oe), 0);
        goto(5, 2);
        chk("R9 recognized after fall", int'(sdata_oe), 1);
        chk("R9 new word msb", int'(sdata), int'(W_E[15]));
        pulse_chk("R5 E bit14", int'(W_E[14]));
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule